// File: doc/BRIEF.md
# Clock Gating and Reset Controller

This block sits between a free-running input clock and the rest of a small processor subsystem. It halves the input clock into an internal rate by issuing a one-cycle enable on every second input clock. That enable is then gated separately for the processor core and for the peripheral and interrupt logic. A two-bit power-control write moves the block into an idle state or a power-down state. Idle stops only the core. Power-down stops every enable and also drops the oscillator-run indication.

The external reset is active high. It is synchronised, then deglitched by a stability filter, so a slowly rising RC edge becomes one clean level. That filtered level wakes the block from either low-power state. The synchronous internal reset asserts only after the filtered level has been sampled high at a set number of consecutive machine-cycle sample points. It releases at the first sample point that sees the filtered level low.

Top module: `pmc_clk_rst_ctrl`

## Requirements
- R1: While running, `periph_ce_o` and `core_ce_o` pulse high on alternate input clocks, never two clocks in a row, and `core_ce_o` is never high without `periph_ce_o`.
- R2: A write with bit 0 of `pctl_wdata_i` set (bit 1 clear) in the running state stops `core_ce_o` from the next clock. `periph_ce_o` keeps alternating and `osc_run_o` stays high.
- R3: `irq_pend_i` high during idle returns the block to the running state on the next clock.
- R4: A write with bit 1 of `pctl_wdata_i` set enters power-down, which holds `core_ce_o`, `periph_ce_o` and `osc_run_o` low. Bit 1 wins when bits 0 and 1 are both written.
- R5: `irq_pend_i` and writes have no effect in power-down, and writes have no effect in idle.
- R6: A filtered reset leaves idle or power-down and clears both modes. After `rst_raw_i` rises, `osc_run_o` is high again exactly SYNC_STAGES + FILT_CLKS + 1 clocks later.
- R7: A pulse on `rst_raw_i` shorter than FILT_CLKS input clocks changes nothing: an idle block stays idle and `rst_sync_o` stays low.
- R8: `rst_sync_o` rises only at a sample point, one per MC_CLKS input clocks, that completes RST_MCS consecutive high samples of the filtered reset. A raw reset held for MC_CLKS clocks or fewer never asserts it.
- R9: `rst_sync_o` stays high while `rst_raw_i` is held. It falls at the first sample point after the filtered reset drops, within SYNC_STAGES + FILT_CLKS + 1 to SYNC_STAGES + FILT_CLKS + MC_CLKS clocks of release.
- R10: A write with both mode bits clear leaves the running state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock |
| rst_raw_i | input | 1 | External reset, active high, asynchronous and possibly slow |
| pctl_we_i | input | 1 | Power-control write strobe |
| pctl_wdata_i | input | 2 | Write data: bit 0 requests idle, bit 1 requests power-down |
| irq_pend_i | input | 1 | Interrupt pending, wakes idle |
| core_ce_o | output | 1 | Core clock enable at half the input rate |
| periph_ce_o | output | 1 | Peripheral and interrupt clock enable at half the input rate |
| osc_run_o | output | 1 | Oscillator run request, low in power-down |
| rst_sync_o | output | 1 | Qualified synchronous internal reset |

## Verification
The bench builds the block with a twelve-clock machine cycle, sample phase 5, two required samples, a two-stage synchroniser and a four-clock filter. These values keep every reset window short enough to measure to the exact clock edge. The filter edge can be probed with three-clock and six-clock pulses. A twelve-clock pulse shows that a single sample point never qualifies a reset. Because the machine-cycle phase is unknown at reset release, the reset assertion and release latencies are checked against the window that the sample spacing allows.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int PCTL_W      = 2;
    localparam int PCTL_IDLE_B = 0;
    localparam int PCTL_DOWN_B = 1;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_state_e;

    typedef struct packed {
        pm_state_e st;
    } pm_regs_t;

endpackage

// File: rtl/pmc_timebase.sv
module pmc_timebase #(
    parameter int MC_CLKS      = 12,
    parameter int SAMPLE_PHASE = 5
) (
    input  logic clk_i,
    output logic half_o,
    output logic sample_o
);
    localparam int PH_W = $clog2(MC_CLKS);

    typedef struct packed {
        logic            half;
        logic [PH_W-1:0] phase;
    } tb_regs_t;

    tb_regs_t d, q;

    // free-running; converges from any power-up value
    always_comb begin
        d.half  = ~q.half;
        d.phase = (q.phase >= PH_W'(MC_CLKS - 1)) ? '0 : q.phase + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        q <= d;
    end

    assign half_o   = q.half;
    assign sample_o = (q.phase == PH_W'(SAMPLE_PHASE));

endmodule

// File: rtl/pmc_rst_filter.sv
module pmc_rst_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CLKS   = 4
) (
    input  logic clk_i,
    input  logic rst_raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(FILT_CLKS + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   filt;
        logic [CW-1:0]          cnt;
    } flt_regs_t;

    flt_regs_t d, q;
    logic      lvl;

    assign lvl = q.sync[SYNC_STAGES-1];

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], rst_raw_i};
        if (lvl == q.filt) begin
            d.cnt = '0;
        end else if (q.cnt >= CW'(FILT_CLKS - 1)) begin
            d.filt = lvl;
            d.cnt  = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        q <= d;
    end

    assign filt_o = q.filt;

endmodule

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int RST_MCS = 2
) (
    input  logic clk_i,
    input  logic sample_i,
    input  logic filt_i,
    output logic rst_o
);
    localparam int CW = $clog2(RST_MCS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst;
    } ql_regs_t;

    ql_regs_t d, q;

    always_comb begin
        d = q;
        if (sample_i) begin
            if (filt_i) begin
                if (q.cnt < CW'(RST_MCS)) d.cnt = q.cnt + 1'b1;
                d.rst = (q.cnt >= CW'(RST_MCS - 1));
            end else begin
                d.cnt = '0;
                d.rst = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        q <= d;
    end

    assign rst_o = q.rst;

endmodule

// File: rtl/pmc_pwr_fsm.sv
module pmc_pwr_fsm
    import pmc_pkg::*;
(
    input  logic              clk_i,
    input  logic              wake_rst_i,
    input  logic              pctl_we_i,
    input  logic [PCTL_W-1:0] pctl_wdata_i,
    input  logic              irq_pend_i,
    input  logic              half_i,
    output logic              core_ce_o,
    output logic              periph_ce_o,
    output logic              osc_run_o
);
    pm_regs_t d, q;

    always_comb begin
        d = q;
        if (wake_rst_i) begin
            d.st = PM_RUN;
        end else begin
            case (q.st)
                PM_RUN: begin
                    if (pctl_we_i) begin
                        if (pctl_wdata_i[PCTL_DOWN_B])      d.st = PM_DOWN;
                        else if (pctl_wdata_i[PCTL_IDLE_B]) d.st = PM_IDLE;
                    end
                end
                PM_IDLE: if (irq_pend_i) d.st = PM_RUN;
                PM_DOWN: d.st = PM_DOWN;
                default: d.st = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        q <= d;
    end

    assign core_ce_o   = half_i & (q.st == PM_RUN);
    assign periph_ce_o = half_i & (q.st != PM_DOWN);
    assign osc_run_o   = (q.st != PM_DOWN);

endmodule

// File: rtl/pmc_clk_rst_ctrl.sv
module pmc_clk_rst_ctrl
    import pmc_pkg::*;
#(
    parameter int MC_CLKS      = 12,
    parameter int SAMPLE_PHASE = 5,
    parameter int RST_MCS      = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_CLKS    = 4
) (
    input  logic              clk_i,
    input  logic              rst_raw_i,
    input  logic              pctl_we_i,
    input  logic [PCTL_W-1:0] pctl_wdata_i,
    input  logic              irq_pend_i,
    output logic              core_ce_o,
    output logic              periph_ce_o,
    output logic              osc_run_o,
    output logic              rst_sync_o
);
    logic half;
    logic sample_stb;
    logic rst_filt;

    pmc_timebase #(
        .MC_CLKS      (MC_CLKS),
        .SAMPLE_PHASE (SAMPLE_PHASE)
    ) u_timebase (
        .clk_i    (clk_i),
        .half_o   (half),
        .sample_o (sample_stb)
    );

    pmc_rst_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_CLKS   (FILT_CLKS)
    ) u_filter (
        .clk_i     (clk_i),
        .rst_raw_i (rst_raw_i),
        .filt_o    (rst_filt)
    );

    pmc_rst_qual #(
        .RST_MCS (RST_MCS)
    ) u_qual (
        .clk_i    (clk_i),
        .sample_i (sample_stb),
        .filt_i   (rst_filt),
        .rst_o    (rst_sync_o)
    );

    pmc_pwr_fsm u_fsm (
        .clk_i        (clk_i),
        .wake_rst_i   (rst_filt),
        .pctl_we_i    (pctl_we_i),
        .pctl_wdata_i (pctl_wdata_i),
        .irq_pend_i   (irq_pend_i),
        .half_i       (half),
        .core_ce_o    (core_ce_o),
        .periph_ce_o  (periph_ce_o),
        .osc_run_o    (osc_run_o)
    );

endmodule

// File: rtl/pmc_clk_rst_ctrl_chk.sv
module pmc_clk_rst_ctrl_chk (
    input logic clk_i,
    input logic rst_raw_i,
    input logic core_ce_o,
    input logic periph_ce_o,
    input logic osc_run_o,
    input logic rst_sync_o,
    input logic rst_filt,
    input logic sample_stb
);
    a_r1_periph_alternates: assert property (@(posedge clk_i) disable iff (rst_raw_i)
        periph_ce_o |=> !periph_ce_o);

    a_r1_core_within_periph: assert property (@(posedge clk_i) disable iff (rst_raw_i)
        core_ce_o |-> periph_ce_o);

    a_r4_down_gates_all: assert property (@(posedge clk_i) disable iff (rst_raw_i)
        !osc_run_o |-> (!periph_ce_o && !core_ce_o));

    a_r5_down_holds: assert property (@(posedge clk_i) disable iff (rst_raw_i)
        (!osc_run_o && !rst_filt) |=> !osc_run_o);

    a_r6_wake_restores_osc: assert property (@(posedge clk_i) disable iff (rst_raw_i)
        rst_filt |=> osc_run_o);

    a_r8_rise_at_sample: assert property (@(posedge clk_i) disable iff (rst_raw_i)
        $rose(rst_sync_o) |-> ($past(sample_stb) && $past(rst_filt)));

    a_r9_fall_at_sample: assert property (@(posedge clk_i) disable iff (rst_raw_i)
        $fell(rst_sync_o) |-> ($past(sample_stb) && !$past(rst_filt)));

endmodule

bind pmc_clk_rst_ctrl pmc_clk_rst_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .rst_raw_i   (rst_raw_i),
    .core_ce_o   (core_ce_o),
    .periph_ce_o (periph_ce_o),
    .osc_run_o   (osc_run_o),
    .rst_sync_o  (rst_sync_o),
    .rst_filt    (rst_filt),
    .sample_stb  (sample_stb)
);

// File: tb/pmc_clk_rst_ctrl_tb.sv
module pmc_clk_rst_ctrl_tb;
    localparam int MC  = 12;
    localparam int SPH = 5;
    localparam int RMC = 2;
    localparam int SYN = 2;
    localparam int FLT = 4;
    localparam int LAT = SYN + FLT + 1;
    localparam int NV  = 10;

    // {we, wdata[1:0], irq, exp_core, exp_periph, exp_osc}
    localparam logic [6:0] VEC [NV] = '{
        7'b0_00_0_111,  // R1 running
        7'b1_00_0_111,  // R10 empty write
        7'b1_01_0_011,  // R2 enter idle
        7'b1_10_0_011,  // R5 write ignored in idle
        7'b0_00_1_111,  // R3 irq wakes idle
        7'b1_01_0_011,  // R2 idle again
        7'b0_00_1_111,  // R3 wake again
        7'b1_11_0_000,  // R4 both bits, power-down wins
        7'b0_00_1_000,  // R5 irq ignored in power-down
        7'b1_01_0_000   // R5 write ignored in power-down
    };

    logic       clk = 1'b0;
    logic       rst_raw = 1'b1;
    logic       we = 1'b0;
    logic [1:0] wd = 2'b00;
    logic       irq = 1'b0;
    logic       core_ce, periph_ce, osc_run, rst_sync;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  seen   = 1'b0;

    always #5 clk = ~clk;

    pmc_clk_rst_ctrl #(
        .MC_CLKS(MC), .SAMPLE_PHASE(SPH), .RST_MCS(RMC),
        .SYNC_STAGES(SYN), .FILT_CLKS(FLT)
    ) u_dut (
        .clk_i(clk), .rst_raw_i(rst_raw), .pctl_we_i(we), .pctl_wdata_i(wd),
        .irq_pend_i(irq), .core_ce_o(core_ce), .periph_ce_o(periph_ce),
        .osc_run_o(osc_run), .rst_sync_o(rst_sync)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input string what, input int act,
                           input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    // samples two consecutive negedges, ORs the half-rate enables
    task automatic observe(output logic c, output logic p, output logic o);
        logic c1, p1;
        c1 = core_ce; p1 = periph_ce; o = osc_run;
        @(negedge clk);
        c = c1 | core_ce;
        p = p1 | periph_ce;
    endtask

    task automatic watch(input int n);
        repeat (n) begin
            @(negedge clk);
            if (rst_sync) seen = 1'b1;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            summary();
            $finish;
        end
    end

    initial begin
        logic c, p, o;
        int   k;

        // reset state, R9 held reset
        repeat (60) @(negedge clk);
        chk("R9", "rst_sync during held reset", int'(rst_sync), 1);
        chk("R6", "osc_run during reset", int'(osc_run), 1);
        rst_raw = 1'b0;
        repeat (30) @(negedge clk);
        chk("R9", "rst_sync after release", int'(rst_sync), 0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            we = VEC[i][6]; wd = VEC[i][5:4]; irq = VEC[i][3];
            @(negedge clk);
            we = 1'b0; wd = 2'b00; irq = 1'b0;
            observe(c, p, o);
            chk($sformatf("vec%0d", i), "core_ce", int'(c), int'(VEC[i][2]));
            chk($sformatf("vec%0d", i), "periph_ce", int'(p), int'(VEC[i][1]));
            chk($sformatf("vec%0d", i), "osc_run", int'(o), int'(VEC[i][0]));
        end

        // R6 wake from power-down, R8 assertion window
        rst_raw = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!osc_run && k < 100);
        chk("R6", "clocks to osc_run after raw reset", k, LAT);
        while (!rst_sync && k < 200) begin @(negedge clk); k++; end
        chk_rng("R8", "clocks to rst_sync rise", k, LAT + (RMC - 1) * MC, LAT + RMC * MC - 1);
        while (k < 50) begin @(negedge clk); k++; end
        chk("R9", "rst_sync while raw held", int'(rst_sync), 1);
        rst_raw = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (rst_sync && k < 100);
        chk_rng("R9", "clocks to rst_sync fall", k, LAT, SYN + FLT + MC);
        observe(c, p, o);
        chk("R6", "core_ce after power-down exit", int'(c), 1);
        chk("R6", "osc_run after power-down exit", int'(o), 1);

        // R1 divide by two
        begin
            logic prev;
            int   bad;
            bad = 0;
            prev = periph_ce;
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                if (periph_ce == prev) bad++;
                if (core_ce != periph_ce) bad++;
                prev = periph_ce;
            end
            chk("R1", "half-rate enable violations", bad, 0);
        end

        // R7 glitch in idle
        we = 1'b1; wd = 2'b01;
        @(negedge clk);
        we = 1'b0; wd = 2'b00;
        seen = 1'b0;
        rst_raw = 1'b1;
        watch(FLT - 1);
        rst_raw = 1'b0;
        watch(20);
        observe(c, p, o);
        chk("R7", "core_ce after short glitch (stays idle)", int'(c), 0);
        chk("R7", "periph_ce after short glitch", int'(p), 1);
        chk("R7", "rst_sync seen on glitch", int'(seen), 0);

        // R6 idle left by a filtered but unqualified reset
        rst_raw = 1'b1;
        watch(FLT + 2);
        rst_raw = 1'b0;
        watch(20);
        observe(c, p, o);
        chk("R6", "core_ce after reset wakes idle", int'(c), 1);
        chk("R8", "rst_sync seen on 6-clock pulse", int'(seen), 0);

        // R8 one machine cycle is not enough
        seen = 1'b0;
        rst_raw = 1'b1;
        watch(MC);
        rst_raw = 1'b0;
        watch(40);
        chk("R8", "rst_sync seen on one-machine-cycle pulse", int'(seen), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule